// File: doc/BRIEF.md
# Expansion ROM Base Register Controller

This block holds the base address register of a configuration header's option ROM window. Software writes a dword to it, reads it back, and writes a pattern of all ones to learn the window size. The block watches every accepted write and tells an external address decoder when the ROM window should appear or disappear. It does this with one-cycle map and unmap pulses that carry the window's base and size.

The ROM address mask is a parameter. The window size is the two's complement of the mask. A mask of zero means the function has no ROM, and the register then stays at zero. The register's place in the header is decided by the surrounding logic: a plain function uses one dword and a bridge uses another. This block only sees the write data that is routed to it.

The write port uses valid/ready. A write is taken on a rising edge where both `wr_valid` and `wr_ready` are high. The writer must hold `wr_valid` and `wr_data` steady while `wr_ready` is low. `wr_ready` goes low for exactly one cycle after a write that moves an active window, because the unmap and the following map each need a cycle of their own.

Top module: `rom_bar_ctrl`

## Requirements
- R1: After reset, `rd_data` is zero, `wr_ready` is high, no pulse is emitted, and no window is recorded as mapped.
- R2: When `ROM_MASK` is zero, every write is ignored: `rd_data` stays zero and no pulse is ever emitted.
- R3: An accepted write stores `wr_data & (ROM_MASK | 1)`, which reads back on `rd_data` the cycle after acceptance. Bit 0 of the stored value is the ROM enable and the address field is `wr_data & ROM_MASK`.
- R4: A write whose data has every `ROM_MASK` bit set is a size probe. It is stored as in R3, emits no pulse, and leaves the recorded mapped address unchanged.
- R5: While a pulse is high, `evt_size` equals `~ROM_MASK + 1` and `evt_base` holds the window address concerned. Both read zero when no pulse is high.
- R6: A non-probe write with enable set and a nonzero address, when no window is mapped, gives one `map_pulse` with that address, in the cycle after acceptance.
- R7: A non-probe write with enable set and a nonzero address that differs from the mapped one gives `unmap_pulse` with the old address in the cycle after acceptance, then `map_pulse` with the new address in the next cycle. `wr_ready` is low during the unmap cycle.
- R8: A non-probe write with enable set and a zero address unmaps any mapped window and clears the record. If nothing is mapped, no pulse is emitted.
- R9: A non-probe write with enable clear unmaps any mapped window and clears the record. Re-enabling the same address later maps it again.
- R10: An enabled write of the address that is already mapped emits no pulse.
- R11: `map_pulse` and `unmap_pulse` are never high in the same cycle. Every pulse follows an accepted write, or a map follows the unmap of a relocation.
- R12: A write presented while `wr_ready` is low is not taken until `wr_ready` returns high. The stored value does not change in the meantime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_data | input | ADDR_W | Dword written to the register |
| rd_data | output | ADDR_W | Current register contents |
| map_pulse | output | 1 | One-cycle request to open the ROM window |
| unmap_pulse | output | 1 | One-cycle request to close the ROM window |
| evt_base | output | ADDR_W | Window address during a pulse, zero otherwise |
| evt_size | output | ADDR_W | Window size during a pulse, zero otherwise |

## Verification
The bench goes after the cases where a design would confuse one write with another:

- **Size probe with the enable bit set.** A design that does not recognise the probe would map the all-ones window.
- **Re-enabling after a disable.** If the mapped record is not cleared, the window is never announced again.
- **Relocation.** A design that drops the first of the two pulses would leave a stale window in the decoder. Pulses in the wrong order would remove the new window at once.
- **A write held against back-pressure.** A design that samples valid without ready would store it early and announce events twice.
- **A zero mask.** A design that does not gate writes here would make a phantom ROM appear.

// File: rtl/rom_bar_pkg.sv
package rom_bar_pkg;

  // Action chosen for one accepted write
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_MAP   = 2'd1,
    ACT_UNMAP = 2'd2,
    ACT_RELOC = 2'd3
  } map_act_e;

  // Event sequencer state
  typedef enum logic {
    SEQ_IDLE     = 1'b0,
    SEQ_MAP_NEXT = 1'b1
  } seq_state_e;

endpackage

// File: rtl/rom_bar_store.sv
module rom_bar_store #(
  parameter int unsigned          ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]    ROM_MASK = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] bar_q
);
  // writable bits: address field plus the enable in bit 0
  localparam logic [ADDR_W-1:0] KEEP = ROM_MASK | {{(ADDR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_q <= '0;
    end else if (wr_en) begin
      bar_q <= wr_data & KEEP;
    end
  end
endmodule

// File: rtl/rom_map_decide.sv
module rom_map_decide
  import rom_bar_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]    ROM_MASK = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] mapped_addr,
  output map_act_e          act,
  output logic [ADDR_W-1:0] new_addr
);
  logic probe;
  logic en;
  logic have_map;

  always_comb begin
    new_addr = wr_data & ROM_MASK;
    probe    = (new_addr == ROM_MASK);
    en       = wr_data[0];
    have_map = (mapped_addr != '0);
    act      = ACT_NONE;
    if (!probe) begin
      if (en && (new_addr != '0)) begin
        if (new_addr != mapped_addr) begin
          act = have_map ? ACT_RELOC : ACT_MAP;
        end
      end else if (have_map) begin
        // enable clear, or enabled with a zero address
        act = ACT_UNMAP;
      end
    end
  end
endmodule

// File: rtl/rom_evt_seq.sv
module rom_evt_seq
  import rom_bar_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]    ROM_MASK = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  map_act_e          act,
  input  logic [ADDR_W-1:0] new_addr,
  output logic [ADDR_W-1:0] mapped_addr,
  output logic              busy,
  output logic              map_pulse,
  output logic              unmap_pulse,
  output logic [ADDR_W-1:0] evt_base,
  output logic [ADDR_W-1:0] evt_size
);
  localparam logic [ADDR_W-1:0] WIN_SIZE = ~ROM_MASK + {{(ADDR_W-1){1'b0}}, 1'b1};

  seq_state_e        state_q;
  logic [ADDR_W-1:0] pend_q;
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      pend_q      <= '0;
      base_q      <= '0;
      mapped_addr <= '0;
      map_pulse   <= 1'b0;
      unmap_pulse <= 1'b0;
    end else begin
      map_pulse   <= 1'b0;
      unmap_pulse <= 1'b0;
      base_q      <= '0;
      if (state_q == SEQ_MAP_NEXT) begin
        map_pulse <= 1'b1;
        base_q    <= pend_q;
        state_q   <= SEQ_IDLE;
      end else if (start) begin
        unique case (act)
          ACT_MAP: begin
            map_pulse   <= 1'b1;
            base_q      <= new_addr;
            mapped_addr <= new_addr;
          end
          ACT_UNMAP: begin
            unmap_pulse <= 1'b1;
            base_q      <= mapped_addr;
            mapped_addr <= '0;
          end
          ACT_RELOC: begin
            unmap_pulse <= 1'b1;
            base_q      <= mapped_addr;
            pend_q      <= new_addr;
            mapped_addr <= new_addr;
            state_q     <= SEQ_MAP_NEXT;
          end
          default: ;
        endcase
      end
    end
  end

  assign busy     = (state_q == SEQ_MAP_NEXT);
  assign evt_base = base_q;
  assign evt_size = (map_pulse || unmap_pulse) ? WIN_SIZE : '0;
endmodule

// File: rtl/rom_bar_ctrl.sv
module rom_bar_ctrl
  import rom_bar_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]    ROM_MASK = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_data,
  output logic              map_pulse,
  output logic              unmap_pulse,
  output logic [ADDR_W-1:0] evt_base,
  output logic [ADDR_W-1:0] evt_size
);
  logic              busy;
  logic              accept;
  logic [ADDR_W-1:0] mapped_addr;
  logic [ADDR_W-1:0] new_addr;
  map_act_e          act;

  assign wr_ready = !busy;

  generate
    if (ROM_MASK == '0) begin : g_no_rom
      // no ROM: writes are dropped entirely
      assign accept = 1'b0;
    end else begin : g_rom
      assign accept = wr_valid && wr_ready;
    end
  endgenerate

  rom_bar_store #(.ADDR_W(ADDR_W), .ROM_MASK(ROM_MASK)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_data (wr_data),
    .bar_q   (rd_data)
  );

  rom_map_decide #(.ADDR_W(ADDR_W), .ROM_MASK(ROM_MASK)) u_decide (
    .wr_data     (wr_data),
    .mapped_addr (mapped_addr),
    .act         (act),
    .new_addr    (new_addr)
  );

  rom_evt_seq #(.ADDR_W(ADDR_W), .ROM_MASK(ROM_MASK)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .act         (act),
    .new_addr    (new_addr),
    .mapped_addr (mapped_addr),
    .busy        (busy),
    .map_pulse   (map_pulse),
    .unmap_pulse (unmap_pulse),
    .evt_base    (evt_base),
    .evt_size    (evt_size)
  );
endmodule

// File: rtl/rom_bar_ctrl_chk.sv
module rom_bar_ctrl_chk #(
  parameter int unsigned          ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]    ROM_MASK = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_data,
  input logic              map_pulse,
  input logic              unmap_pulse,
  input logic [ADDR_W-1:0] evt_base,
  input logic [ADDR_W-1:0] evt_size
);
  localparam logic [ADDR_W-1:0] KEEP = ROM_MASK | {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] WSZ  = ~ROM_MASK + {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam bit HAS_ROM = (ROM_MASK != '0);

  logic take;
  assign take = wr_valid && wr_ready;

  // R11
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(map_pulse && unmap_pulse));

  // R11
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_pulse || unmap_pulse) |-> ($past(take) || $past(unmap_pulse)));

  // R4
  probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ((wr_data & ROM_MASK) == ROM_MASK)) |=> !(map_pulse || unmap_pulse));

  // R3
  store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_ROM && take) |=> (rd_data == ($past(wr_data) & KEEP)));

  // R2
  no_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_ROM |-> (rd_data == '0 && !map_pulse && !unmap_pulse));

  // R5
  size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_pulse || unmap_pulse) |-> (evt_size == WSZ && evt_base != '0));

  // R7
  reloc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> unmap_pulse);

  // R7
  reloc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> (map_pulse && wr_ready));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(rd_data));
endmodule

bind rom_bar_ctrl rom_bar_ctrl_chk #(.ADDR_W(ADDR_W), .ROM_MASK(ROM_MASK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .map_pulse   (map_pulse),
  .unmap_pulse (unmap_pulse),
  .evt_base    (evt_base),
  .evt_size    (evt_size)
);

// File: tb/sim_rom_bar_ctrl.sv
module sim_rom_bar_ctrl;
  localparam int unsigned    W    = 32;
  localparam logic [W-1:0]   MASK = 32'hFFFF_0000;
  localparam logic [W-1:0]   ESZ  = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         map_pulse, unmap_pulse;
  logic [W-1:0] evt_base, evt_size;

  logic         z_valid = 1'b0;
  logic         z_ready;
  logic [W-1:0] z_data = '0;
  logic [W-1:0] z_rd;
  logic         z_map, z_unmap;
  logic [W-1:0] z_base, z_size;

  rom_bar_ctrl #(.ADDR_W(W), .ROM_MASK(MASK)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_data(rd_data), .map_pulse(map_pulse),
    .unmap_pulse(unmap_pulse), .evt_base(evt_base), .evt_size(evt_size)
  );

  rom_bar_ctrl #(.ADDR_W(W), .ROM_MASK('0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_valid(z_valid), .wr_ready(z_ready),
    .wr_data(z_data), .rd_data(z_rd), .map_pulse(z_map),
    .unmap_pulse(z_unmap), .evt_base(z_base), .evt_size(z_size)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // expected event: {is_map, base}
  logic [W:0] expq[$];

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares every pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (map_pulse || unmap_pulse) begin
        vectors++;
        if (expq.size() == 0) begin
          miscompares++;
          $display("FAIL R11: actual unexpected event map=%0b base %h expected none",
                   map_pulse, evt_base);
        end else begin
          logic [W:0] e;
          e = expq.pop_front();
          if (map_pulse !== e[W] || unmap_pulse !== !e[W] || evt_base !== e[W-1:0]
              || evt_size !== ESZ) begin
            miscompares++;
            $display("FAIL R5: actual map=%0b base %h size %h expected map=%0b base %h size %h",
                     map_pulse, evt_base, evt_size, e[W], e[W-1:0], ESZ);
          end
        end
      end else if (evt_base !== '0 || evt_size !== '0) begin
        vectors++;
        miscompares++;
        $display("FAIL R5: actual base %h size %h expected 0 when idle", evt_base, evt_size);
      end
      if (z_map || z_unmap) begin
        vectors++;
        miscompares++;
        $display("FAIL R2: actual pulse from zero-mask instance expected none");
      end
    end
  end

  task automatic expect_evt(input bit is_map, input logic [W-1:0] base);
    expq.push_back({is_map, base});
  endtask

  // one write, then let events drain, then check readback and scoreboard
  task automatic do_write(input string req, input logic [W-1:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check(req, rd_data, d & (MASK | 32'h1));
    repeat (3) @(negedge clk);
    check(req, W'(expq.size()), '0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          miscompares++;
          $display("FAIL watchdog: actual hung expected completion");
          done = 1'b1;
          $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", rd_data, '0);
    check("R1", {31'b0, wr_ready}, 32'h1);
    check("R1", {31'b0, map_pulse | unmap_pulse}, '0);

    // R6 first map
    expect_evt(1'b1, 32'h0002_0000);
    do_write("R6", 32'h0002_0001);
    // R10 same address again: nothing
    do_write("R10", 32'h0002_0001);
    // R4 probe with enable set: nothing
    do_write("R4", 32'hFFFF_FFFF);
    // R4 record kept: rewriting the old address gives no event
    do_write("R4", 32'h0002_0001);

    // R7 relocation with R12 back-pressure
    expect_evt(1'b0, 32'h0002_0000);
    expect_evt(1'b1, 32'h0005_0000);
    expect_evt(1'b0, 32'h0005_0000);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = 32'h0005_0001;
    @(negedge clk);
    check("R7", {31'b0, wr_ready}, '0);
    check("R7", rd_data, 32'h0005_0001);
    wr_data = 32'h0005_0000;
    @(negedge clk);
    check("R12", rd_data, 32'h0005_0001);
    check("R12", {31'b0, wr_ready}, 32'h1);
    @(negedge clk);
    wr_valid = 1'b0;
    check("R9", rd_data, 32'h0005_0000);
    repeat (3) @(negedge clk);
    check("R7", W'(expq.size()), '0);

    // R9 disable again with nothing mapped: nothing
    do_write("R9", 32'h0005_0000);
    // R9 re-enable same address maps again
    expect_evt(1'b1, 32'h0005_0000);
    do_write("R9", 32'h0005_0001);
    // R8 enabled zero address unmaps
    expect_evt(1'b0, 32'h0005_0000);
    do_write("R8", 32'h0000_0001);
    do_write("R8", 32'h0000_0001);
    // R3 low bits dropped, address field maps
    expect_evt(1'b1, 32'h1234_0000);
    do_write("R3", 32'h1234_ABCD);
    // R4 probe with enable clear: no unmap
    do_write("R4", 32'hFFFF_0000);
    // R10 mapping still recorded
    do_write("R10", 32'h1234_0001);

    // R2 zero-mask instance ignores writes
    @(negedge clk);
    z_valid = 1'b1;
    z_data  = 32'hABCD_0001;
    repeat (2) @(negedge clk);
    z_valid = 1'b0;
    check("R2", z_rd, '0);
    repeat (2) @(negedge clk);
    check("R2", z_rd, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule